// File: doc/BRIEF.md
# Directory Controller Occupancy Queue

This block models how busy a directory controller is. Requests are represented by tags that join a first-in, first-out queue. The controller works on one tag at a time, the one at the head of the queue. Each tag holds the controller for a service time chosen by its own delay class. A tag can come from the local-side interface, which uses a shorter controller time, or from the remote-side interface, which uses a longer one. When that time runs out, the head tag is released to whatever stage follows, and the next tag starts its own service time in the same cycle.

A tag that reaches an empty queue starts service right away. A tag that reaches a non-empty queue waits behind every tag ahead of it. When the queue is full the block pushes back on the producer by lowering ready. An enqueue and a release in the same cycle are both carried out.

Top module: `dirctl_occ_queue`

## Requirements
- R1: After reset, `count_o` is 0, `busy_o` and `full_o` are low, `enq_ready_o` is high and `rel_valid_o` is low. `rel_valid_o` is never high while the queue is empty.
- R2: A tag accepted into an empty queue with `enq_remote_i` = 0 (local class) is released LOCAL_DLY cycles after it is accepted. That is, `rel_valid_o` is high in the cycle that starts LOCAL_DLY-1 clock edges after the accepting edge.
- R3: A tag accepted into an empty queue with `enq_remote_i` = 1 (remote class) is released REMOTE_DLY cycles after it is accepted.
- R4: Tags are released on `rel_tag_o` in the same order in which they were accepted.
- R5: At the clock edge that removes the head, the next tag begins its own service. Its release comes exactly its own class delay later, so two releases in a row are separated by the second tag's delay.
- R6: A tag that arrives while another tag is in service does not start its delay until the tag ahead of it has been removed.
- R7: While `count_o` equals DEPTH, `enq_ready_o` is low and an enqueue attempt has no effect. The count does not change, and the rejected tag never appears on `rel_tag_o`.
- R8: When an accepted enqueue and a release happen in the same cycle, the count stays the same. If the queue then holds only the new tag, that tag starts service at that edge.
- R9: `rel_valid_o` is high for exactly one cycle for each accepted tag. After each release the count goes down by one.
- R10: `count_o` gives the number of tags held. `busy_o` is high when that number is non-zero, and `full_o` is high when it equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | High when an enqueue will be accepted |
| enq_tag_i | input | TAG_W | Tag to enqueue |
| enq_remote_i | input | 1 | Delay class of the tag: 0 = local, 1 = remote |
| rel_valid_o | output | 1 | One-cycle pulse: the head tag is released in this cycle |
| rel_tag_o | output | TAG_W | Tag being released, valid with `rel_valid_o` |
| busy_o | output | 1 | Controller occupied (queue non-empty) |
| full_o | output | 1 | Queue holds DEPTH tags |
| count_o | output | $clog2(DEPTH+1) | Number of tags held |

## Verification
The bench records every release and the cycle in which it happened. It targets five cases:
- A mixed local and remote burst. A design that started a waiting tag's delay on arrival, or that applied the head's class to the next tag, would release early or late.
- An enqueue that lands in the very cycle the only tag is released. If this were handled badly, the count would drift or the new tag would never start service.
- An enqueue while the queue is full. A design that let it through would overwrite a stored tag or release a stray one.
- Back-to-back releases. These expose a head that is kept for an extra cycle, which would show up as a doubled pulse.
- The release order. This catches a read pointer that skips or repeats an entry.

// File: rtl/occq_pkg.sv
package occq_pkg;

  typedef enum logic {
    DCLS_LOCAL  = 1'b0,
    DCLS_REMOTE = 1'b1
  } dcls_e;

  function automatic int unsigned occq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/occq_rst_sync.sv
module occq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/occq_fifo.sv
module occq_fifo
  import occq_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int TAG_W = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  dcls_e            push_cls,
  input  logic             pop,
  output logic [TAG_W-1:0] head_tag,
  output dcls_e            next_cls,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

  logic [TAG_W:0]   slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] nxt_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] slot_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // per-slot write enables
  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign slot_we[i] = push && (wr_ptr_q == PTR_W'(i));
  end

  // next-state logic
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_d;
      if (pop)  rd_ptr_q <= rd_ptr_d;
      if (push != pop) cnt_q <= cnt_d;
    end
  end

  // storage: datapath, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= {logic'(push_cls), push_tag};
    end
  end

  assign nxt_ptr  = ptr_inc(rd_ptr_q);
  assign head_tag = slot_q[rd_ptr_q][TAG_W-1:0];
  assign next_cls = dcls_e'(slot_q[nxt_ptr][TAG_W]);
  assign count    = cnt_q;
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_FULL);

endmodule

// File: rtl/occq_svc_timer.sv
module occq_svc_timer
  import occq_pkg::*;
#(
  parameter  int LOCAL_DLY  = 3,
  parameter  int REMOTE_DLY = 5,
  localparam int TMR_W      = $clog2(occq_max(LOCAL_DLY, REMOTE_DLY) + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  dcls_e load_cls,
  input  logic  run,
  output logic  expire
);

  localparam logic [TMR_W-1:0] LOCAL_RELOAD  = TMR_W'(LOCAL_DLY - 1);
  localparam logic [TMR_W-1:0] REMOTE_RELOAD = TMR_W'(REMOTE_DLY - 1);

  logic [TMR_W-1:0] left_q, left_d;
  logic             left_en;

  // next-state logic: reload on head change, else count down while serving
  always_comb begin
    left_d  = left_q;
    left_en = 1'b0;
    if (load) begin
      left_d  = (load_cls == DCLS_REMOTE) ? REMOTE_RELOAD : LOCAL_RELOAD;
      left_en = 1'b1;
    end else if (run && (left_q != '0)) begin
      left_d  = left_q - 1'b1;
      left_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign expire = run && (left_q == '0);

endmodule

// File: rtl/dirctl_occ_queue.sv
module dirctl_occ_queue
  import occq_pkg::*;
#(
  parameter  int DEPTH      = 4,
  parameter  int TAG_W      = 6,
  parameter  int LOCAL_DLY  = 3,
  parameter  int REMOTE_DLY = 5,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  input  logic [TAG_W-1:0] enq_tag_i,
  input  logic             enq_remote_i,
  output logic             rel_valid_o,
  output logic [TAG_W-1:0] rel_tag_o,
  output logic             busy_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             rst_n_sync;
  logic             push, pop;
  logic             q_empty, q_full;
  logic [CNT_W-1:0] q_count;
  dcls_e            push_cls, next_cls, load_cls;
  logic             head_load;

  occq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign push_cls = enq_remote_i ? DCLS_REMOTE : DCLS_LOCAL;
  assign push     = enq_valid_i && !q_full;

  // A new head starts service when the queue fills from empty, or when the
  // head leaves and something (stored or arriving) takes its place.
  always_comb begin
    head_load = 1'b0;
    load_cls  = push_cls;
    if (q_empty) begin
      head_load = push;
    end else if (pop) begin
      if (q_count != CNT_ONE) begin
        head_load = 1'b1;
        load_cls  = next_cls;
      end else begin
        head_load = push;
      end
    end
  end

  occq_fifo #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .push     (push),
    .push_tag (enq_tag_i),
    .push_cls (push_cls),
    .pop      (pop),
    .head_tag (rel_tag_o),
    .next_cls (next_cls),
    .count    (q_count),
    .empty    (q_empty),
    .full     (q_full)
  );

  occq_svc_timer #(
    .LOCAL_DLY  (LOCAL_DLY),
    .REMOTE_DLY (REMOTE_DLY)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (head_load),
    .load_cls (load_cls),
    .run      (!q_empty),
    .expire   (pop)
  );

  assign enq_ready_o = !q_full;
  assign rel_valid_o = pop;
  assign busy_o      = !q_empty;
  assign full_o      = q_full;
  assign count_o     = q_count;

endmodule

// File: rtl/occq_checker.sv
module occq_checker #(
  parameter  int DEPTH      = 4,
  parameter  int LOCAL_DLY  = 3,
  parameter  int REMOTE_DLY = 5,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic             rel_valid,
  input logic             busy,
  input logic             full,
  input logic [CNT_W-1:0] count
);

  logic seen_q;
  logic accept;

  assign accept = enq_valid && enq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1: no release while nothing is held
  a_r1_no_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rel_valid);

  // R7: an enqueue against a full queue leaves the count untouched
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && enq_valid && !rel_valid) |=> (count == $past(count)));

  // R8: count follows accepts minus releases
  a_r8_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (int'(count) == int'($past(count)) + int'($past(accept)) - int'($past(rel_valid))));

  // R9: releasing the last tag with no arrival empties the queue
  a_r9_last_release_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && (count == CNT_W'(1)) && !accept) |=> !busy);

  // R5: with both delays above one cycle, releases never come back to back
  if (LOCAL_DLY > 1 && REMOTE_DLY > 1) begin : g_gap
    a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |=> !rel_valid);
  end

endmodule

bind dirctl_occ_queue occq_checker #(
  .DEPTH      (DEPTH),
  .LOCAL_DLY  (LOCAL_DLY),
  .REMOTE_DLY (REMOTE_DLY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .enq_valid (enq_valid_i),
  .enq_ready (enq_ready_o),
  .rel_valid (rel_valid_o),
  .busy      (busy_o),
  .full      (full_o),
  .count     (count_o)
);

// File: tb/tb_dirctl_occ_queue.sv
module tb_dirctl_occ_queue;

  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int LD    = 3;
  localparam int RD    = 5;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk, rst_n;
  logic             enq_valid, enq_ready, enq_remote;
  logic [TAG_W-1:0] enq_tag, rel_tag;
  logic             rel_valid, busy, full;
  logic [CW-1:0]    count;

  int cyc, n_chk, n_fail, nrel;
  int log_tag [64];
  int log_cyc [64];

  dirctl_occ_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LOCAL_DLY(LD), .REMOTE_DLY(RD)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid_i(enq_valid), .enq_ready_o(enq_ready),
    .enq_tag_i(enq_tag), .enq_remote_i(enq_remote), .rel_valid_o(rel_valid),
    .rel_tag_o(rel_tag), .busy_o(busy), .full_o(full), .count_o(count));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rel_valid && nrel < 64) begin
      log_tag[nrel] = int'(rel_tag);
      log_cyc[nrel] = cyc;
      nrel = nrel + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R9 watchdog: cycles=%0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sync_in();
    @(negedge clk); #1;
  endtask

  // present one tag for one cycle; report its accepting edge
  task automatic drive(input int tag, input bit rem, output int edge_n, output bit taken);
    enq_valid  = 1'b1;
    enq_tag    = TAG_W'(tag);
    enq_remote = rem;
    taken      = enq_ready;
    edge_n     = cyc + 1;
    sync_in();
  endtask

  task automatic idle();
    enq_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 200 && busy; i++) sync_in();
    sync_in();
  endtask

  task automatic chk_rel(input int idx, input int tag, input int when, input string req);
    chk(log_tag[idx] == tag, req, "release tag", log_tag[idx], tag);
    chk(log_cyc[idx] == when, req, "release cycle", log_cyc[idx], when);
  endtask

  task automatic t_reset();
    chk(count == 0, "R1", "count after reset", int'(count), 0);
    chk(!busy && !full, "R1", "busy/full after reset", int'({busy, full}), 0);
    chk(enq_ready, "R1", "ready after reset", int'(enq_ready), 1);
    chk(!rel_valid, "R1", "release after reset", int'(rel_valid), 0);
  endtask

  task automatic t_single(input bit rem, input int tag);
    int base, t; bit tk;
    base = nrel;
    drive(tag, rem, t, tk);
    idle();
    chk(count == 1 && busy && !full, "R10", "status with one tag", int'(count), 1);
    drain();
    chk(nrel - base == 1, "R9", "pulses per tag", nrel - base, 1);
    if (rem) chk_rel(base, tag, t + RD - 1, "R3");
    else     chk_rel(base, tag, t + LD - 1, "R2");
  endtask

  task automatic t_burst();
    int base, t0, tx; bit tk;
    base = nrel;
    drive(8'h11, 1'b0, t0, tk);
    drive(8'h12, 1'b1, tx, tk);
    drive(8'h13, 1'b0, tx, tk);
    drive(8'h14, 1'b1, tx, tk);
    idle();
    chk(count == 3, "R8", "count after push+release", int'(count), 3);
    drain();
    chk(nrel - base == 4, "R9", "burst pulses", nrel - base, 4);
    chk_rel(base,     8'h11, t0 + LD - 1,            "R4");
    chk_rel(base + 1, 8'h12, t0 + LD + RD - 1,       "R6");
    chk_rel(base + 2, 8'h13, t0 + 2*LD + RD - 1,     "R5");
    chk_rel(base + 3, 8'h14, t0 + 2*LD + 2*RD - 1,   "R5");
  endtask

  task automatic t_full();
    int base, t0, tx; bit tk;
    base = nrel;
    for (int i = 0; i < DEPTH; i++) drive(8'h20 + i, 1'b1, (i == 0) ? t0 : tx, tk);
    idle();
    chk(full && count == CW'(DEPTH), "R10", "full flag", int'(count), DEPTH);
    chk(!enq_ready, "R7", "ready while full", int'(enq_ready), 0);
    drive(8'h3F, 1'b0, tx, tk);
    idle();
    chk(!tk, "R7", "full enqueue taken", int'(tk), 0);
    chk(count == CW'(DEPTH), "R7", "count after rejected enqueue", int'(count), DEPTH);
    drain();
    chk(nrel - base == DEPTH, "R7", "releases after full", nrel - base, DEPTH);
    for (int i = 0; i < DEPTH; i++) chk_rel(base + i, 8'h20 + i, t0 + (i + 1) * RD - 1, "R4");
    for (int i = base; i < nrel; i++) chk(log_tag[i] != 8'h3F, "R7", "rejected tag released", log_tag[i], -1);
  endtask

  task automatic t_simul();
    int base, t0, t1; bit tk;
    base = nrel;
    drive(8'h05, 1'b0, t0, tk);
    idle();
    while (cyc < t0 + LD - 1) sync_in();
    chk(rel_valid, "R8", "release visible before push", int'(rel_valid), 1);
    drive(8'h06, 1'b1, t1, tk);
    idle();
    chk(count == 1, "R8", "count after simultaneous push/release", int'(count), 1);
    drain();
    chk_rel(base,     8'h05, t0 + LD - 1, "R2");
    chk_rel(base + 1, 8'h06, t1 + RD - 1, "R8");
  endtask

  initial begin
    cyc = 0; n_chk = 0; n_fail = 0; nrel = 0;
    enq_valid = 1'b0; enq_tag = '0; enq_remote = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) sync_in();
    t_reset();
    t_single(1'b0, 8'h07);
    t_single(1'b1, 8'h2A);
    t_burst();
    t_full();
    t_simul();
    chk(!busy && count == 0, "R10", "idle at end", int'(count), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule